// File: doc/BRIEF.md
# Multi-Mode Timer Counter Channel

This block is one 16-bit counting channel for a timer group. It takes a primary count source, chosen from four external pins, four neighbour-channel outputs or eight power-of-two divisions of the system clock. It also takes a secondary input, chosen from the four pins. A 3-bit mode field sets what counts as a count event and which way the count moves. The modes are plain edge counting, gated counting, quadrature decoding, direction taken from the secondary input, one-shot triggered counting and cascade counting.

Counting up, the counter is compared with compare register 1. Counting down, it is compared with compare register 2. A count event that finds the counter equal to the active compare value reloads the counter from the load register and pulses the matching hit output. A sticky overflow flag records any wrap through the 16-bit range.

Pin inputs pass through a two-flop synchronizer and an edge detector in the system clock domain. Clock division produces single-cycle enable pulses, never a derived clock. A controller state machine has five states:

- STOP: mode 0.
- RUN: free-running modes 1 to 5 and 7.
- ARMED: mode 6, waiting for a secondary rising edge.
- FIRE: mode 6, counting primary edges.
- DONE: mode 6, after the compare reload.

The transitions are:

- Mode 0 leads from any state to STOP.
- Any mode other than 0 or 6 leads from any state to RUN.
- Mode 6 leads from STOP or RUN to ARMED.
- A secondary rising edge moves ARMED to FIRE.
- A compare reload moves FIRE to DONE.
- DONE holds while the mode stays 6.

Top module: `tmr_chan`

## Requirements
- R1: After reset the count is 0, both hit outputs are 0 and the overflow flag is 0.
- R2: With mode 0 the count holds its value on every cycle.
- R3: Primary select codes 8 to 15 give one count event every 2^(code-8) system clock cycles, so code 8 counts every cycle, code 11 every 8 cycles and code 15 every 128 cycles.
- R4: Primary select codes 0 to 3 choose pin 0 to 3. Mode 1 counts rising edges of the chosen pin. Mode 2 counts rising and falling edges. In modes 1, 2, 3 and 6, `cfg_down`=1 counts down and `cfg_down`=0 counts up.
- R5: Mode 3 counts primary rising edges only while the secondary pin, picked by `cfg_ssrc` (0 to 3 = pin 0 to 3), is high.
- R6: On a count event going up with count equal to `cfg_cmp1`, the count loads `cfg_load` and `cmp1_hit_o` is high for exactly the cycle in which the count first shows the loaded value. Going down, `cfg_cmp2` and `cmp2_hit_o` behave the same way.
- R7: `ovf_o` sets when a count event steps from 0xFFFF up to 0 or from 0 down to 0xFFFF. It stays set until a cycle with `ovf_clr_i` high.
- R8: In mode 4, with A = primary and B = secondary, the steps (A,B) 00→01→11→10→00 count up by one each and the reverse steps count down by one. A change of both bits at once leaves the count unchanged.
- R9: Mode 5 counts primary rising edges, down while the secondary pin is high and up while it is low.
- R10: In mode 6 the count holds until a secondary rising edge. It then counts primary events until the compare reload, after which it holds the loaded value while the mode stays 6, whatever further secondary edges arrive.
- R11: In mode 7 with primary codes 4 to 7 (neighbour 0 to 3), each rising edge of the chosen neighbour output counts one step. The step is down when that neighbour's `nbr_dir_i` bit is 1 and up when it is 0. Unselected neighbours have no effect.
- R12: With `dbg_i` high and `cfg_dbg` bit 0 set (codes 1 and 3), the count is frozen.
- R13: With `dbg_i` high and `cfg_dbg` bit 1 set (codes 2 and 3), both hit outputs stay 0 while counting goes on. With `dbg_i` low the debug code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 4 | External input pins (asynchronous) |
| nbr_i | input | 4 | Neighbour channel outputs (system clock domain) |
| nbr_dir_i | input | 4 | Neighbour count direction, 1 = down |
| cfg_mode | input | 3 | Count mode 0 to 7 |
| cfg_psrc | input | 4 | Primary source select |
| cfg_ssrc | input | 2 | Secondary pin select |
| cfg_down | input | 1 | Direction for modes 1, 2, 3, 6 (1 = down) |
| cfg_load | input | 16 | Reload value |
| cfg_cmp1 | input | 16 | Compare value when counting up |
| cfg_cmp2 | input | 16 | Compare value when counting down |
| cfg_dbg | input | 2 | Debug action: bit 0 halts, bit 1 forces hits low |
| dbg_i | input | 1 | Debug state active |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| cnt_o | output | 16 | Current count |
| cmp1_hit_o | output | 1 | Up-compare reload pulse |
| cmp2_hit_o | output | 1 | Down-compare reload pulse |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
A wrong controller state shows up at `cnt_o`. A channel stuck in ARMED or DONE never moves, and a channel stuck in FIRE keeps reloading past the one-shot. Either is visible within the few cycles a test waits. A broken quadrature or edge detector shows up as a count delta off by one or more after a known pin sequence, read two to three cycles after the last pin change because of the synchronizer. Compare faults show up as a hit pulse whose cycle does not show the load value. A lost or stuck overflow bit appears at `ovf_o` the cycle after the wrap or the clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int N_IN   = 4;
    localparam int PRE_W  = 7;

    typedef enum logic [2:0] {
        ST_STOP,
        ST_RUN,
        ST_ARMED,
        ST_FIRE,
        ST_DONE
    } run_state_e;

    localparam logic [2:0] M_OFF     = 3'd0;
    localparam logic [2:0] M_RISE    = 3'd1;
    localparam logic [2:0] M_BOTH    = 3'd2;
    localparam logic [2:0] M_GATED   = 3'd3;
    localparam logic [2:0] M_QUAD    = 3'd4;
    localparam logic [2:0] M_SECDIR  = 3'd5;
    localparam logic [2:0] M_ONESHOT = 3'd6;
    localparam logic [2:0] M_CASCADE = 3'd7;
endpackage

// File: rtl/tmr_src.sv
module tmr_src
    import tmr_pkg::*;
#(
    parameter int NIN  = N_IN,
    parameter int PREW = PRE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIN-1:0] pin_i,
    input  logic [NIN-1:0] nbr_i,
    input  logic [NIN-1:0] nbr_dir_i,
    input  logic [3:0]     psrc,
    input  logic [1:0]     ssrc,
    output logic           p_rise,
    output logic           p_fall,
    output logic           p_dir,
    output logic           s_lvl,
    output logic           s_rise,
    output logic           q_up,
    output logic           q_dn
);
    localparam int MW = PREW + 1;

    logic [NIN-1:0]  sync1_q, sync2_q;
    logic [PREW-1:0] pre_q;
    logic            p_prev_q, s_prev_q;
    logic            p_now, s_now, pre_tick;
    logic            sel_pin, sel_nbr, sel_pre;
    logic [MW-1:0]   mask_w;
    logic [1:0]      g_now, g_prev, g_diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q  <= '0;
            sync2_q  <= '0;
            pre_q    <= '0;
            p_prev_q <= 1'b0;
            s_prev_q <= 1'b0;
        end else begin
            sync1_q  <= pin_i;
            sync2_q  <= sync1_q;
            pre_q    <= pre_q + 1'b1;
            p_prev_q <= p_now;
            s_prev_q <= s_now;
        end
    end

    always_comb begin
        sel_pin  = (psrc[3:2] == 2'b00);
        sel_nbr  = (psrc[3:2] == 2'b01);
        sel_pre  = psrc[3];
        mask_w   = (MW'(1) << psrc[2:0]) - MW'(1);
        pre_tick = ((pre_q & mask_w[PREW-1:0]) == mask_w[PREW-1:0]);
        p_now    = sel_pin ? sync2_q[psrc[1:0]] :
                   sel_nbr ? nbr_i[psrc[1:0]] : 1'b0;
        s_now    = sync2_q[ssrc];
        p_rise   = sel_pre ? pre_tick : (p_now & ~p_prev_q);
        p_fall   = sel_pre ? 1'b0 : (~p_now & p_prev_q);
        p_dir    = nbr_dir_i[psrc[1:0]];
        s_lvl    = s_now;
        s_rise   = s_now & ~s_prev_q;
        g_now    = {p_now, p_now ^ s_now};
        g_prev   = {p_prev_q, p_prev_q ^ s_prev_q};
        g_diff   = g_now - g_prev;
        q_up     = (g_diff == 2'd1);
        q_dn     = (g_diff == 2'd3);
    end
endmodule

// File: rtl/tmr_ctl.sv
module tmr_ctl
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       cfg_down,
    input  logic       halt,
    input  logic       p_rise,
    input  logic       p_fall,
    input  logic       p_dir,
    input  logic       s_lvl,
    input  logic       s_rise,
    input  logic       q_up,
    input  logic       q_dn,
    input  logic       match,
    output logic       evt,
    output logic       up
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (mode == M_ONESHOT)  state_d = ST_ARMED;
                else if (mode != M_OFF) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (mode == M_OFF)          state_d = ST_STOP;
                else if (mode == M_ONESHOT) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (mode == M_OFF)          state_d = ST_STOP;
                else if (mode != M_ONESHOT) state_d = ST_RUN;
                else if (s_rise && !halt)   state_d = ST_FIRE;
            end
            ST_FIRE: begin
                if (mode == M_OFF)          state_d = ST_STOP;
                else if (mode != M_ONESHOT) state_d = ST_RUN;
                else if (match)             state_d = ST_DONE;
            end
            ST_DONE: begin
                if (mode == M_OFF)          state_d = ST_STOP;
                else if (mode != M_ONESHOT) state_d = ST_RUN;
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_comb begin
        evt = 1'b0;
        up  = !cfg_down;
        unique case (state_q)
            ST_RUN: begin
                case (mode)
                    M_RISE:    evt = p_rise;
                    M_BOTH:    evt = p_rise | p_fall;
                    M_GATED:   evt = p_rise & s_lvl;
                    M_QUAD: begin
                        evt = q_up | q_dn;
                        up  = q_up;
                    end
                    M_SECDIR: begin
                        evt = p_rise;
                        up  = !s_lvl;
                    end
                    M_CASCADE: begin
                        evt = p_rise;
                        up  = !p_dir;
                    end
                    default:   evt = 1'b0;
                endcase
            end
            ST_FIRE:  evt = (mode == M_ONESHOT) && p_rise;
            ST_STOP, ST_ARMED, ST_DONE: evt = 1'b0;
            default:  evt = 1'b0;
        endcase
        if (halt) evt = 1'b0;
    end

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && mode == M_ONESHOT) |=> (state_q == ST_DONE)); // R10
    AST_ARMED_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && state_d == ST_FIRE) |-> (s_rise && mode == M_ONESHOT)); // R10
endmodule

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
    parameter int W = tmr_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic         up,
    input  logic [W-1:0] load,
    input  logic [W-1:0] cmp1,
    input  logic [W-1:0] cmp2,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic         hit1,
    output logic         hit2,
    output logic         ovf,
    output logic         match
);
    logic m1, m2, wrap;

    always_comb begin
        m1    = evt && up && (cnt == cmp1);
        m2    = evt && !up && (cnt == cmp2);
        match = m1 | m2;
        wrap  = evt && !match &&
                ((up && (cnt == {W{1'b1}})) || (!up && (cnt == '0)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            hit1 <= 1'b0;
            hit2 <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            hit1 <= m1;
            hit2 <= m2;
            if (match)    cnt <= load;
            else if (evt) cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
            if (wrap)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    AST_RELOAD_UP: assert property (@(posedge clk) disable iff (!rst_n)
        hit1 |-> (cnt == $past(load))); // R6
    AST_RELOAD_DN: assert property (@(posedge clk) disable iff (!rst_n)
        hit2 |-> (cnt == $past(load))); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> (cnt == $past(cnt))); // R2
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   pin_i,
    input  logic [3:0]   nbr_i,
    input  logic [3:0]   nbr_dir_i,
    input  logic [2:0]   cfg_mode,
    input  logic [3:0]   cfg_psrc,
    input  logic [1:0]   cfg_ssrc,
    input  logic         cfg_down,
    input  logic [W-1:0] cfg_load,
    input  logic [W-1:0] cfg_cmp1,
    input  logic [W-1:0] cfg_cmp2,
    input  logic [1:0]   cfg_dbg,
    input  logic         dbg_i,
    input  logic         ovf_clr_i,
    output logic [W-1:0] cnt_o,
    output logic         cmp1_hit_o,
    output logic         cmp2_hit_o,
    output logic         ovf_o
);
    logic p_rise, p_fall, p_dir, s_lvl, s_rise, q_up, q_dn;
    logic evt, up, match, hit1, hit2, halt, force_lo;

    assign halt     = dbg_i && cfg_dbg[0];
    assign force_lo = dbg_i && cfg_dbg[1];

    tmr_src #(.NIN(4), .PREW(PRE_W)) u_src (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .nbr_i(nbr_i),
        .nbr_dir_i(nbr_dir_i), .psrc(cfg_psrc), .ssrc(cfg_ssrc),
        .p_rise(p_rise), .p_fall(p_fall), .p_dir(p_dir), .s_lvl(s_lvl),
        .s_rise(s_rise), .q_up(q_up), .q_dn(q_dn)
    );

    tmr_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .cfg_down(cfg_down),
        .halt(halt), .p_rise(p_rise), .p_fall(p_fall), .p_dir(p_dir),
        .s_lvl(s_lvl), .s_rise(s_rise), .q_up(q_up), .q_dn(q_dn),
        .match(match), .evt(evt), .up(up)
    );

    tmr_cnt #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .evt(evt), .up(up), .load(cfg_load),
        .cmp1(cfg_cmp1), .cmp2(cfg_cmp2), .ovf_clr(ovf_clr_i),
        .cnt(cnt_o), .hit1(hit1), .hit2(hit2), .ovf(ovf_o), .match(match)
    );

    assign cmp1_hit_o = hit1 && !force_lo;
    assign cmp2_hit_o = hit2 && !force_lo;

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (cnt_o == $past(cnt_o))); // R12
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == M_OFF) |=> (cnt_o == $past(cnt_o))); // R2
    AST_HIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp1_hit_o && cmp2_hit_o)); // R6
endmodule

// File: tb/tb_tmr_chan.sv
module tb_tmr_chan;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_i = '0, nbr_i = '0, nbr_dir_i = '0;
    logic [2:0]  cfg_mode = '0;
    logic [3:0]  cfg_psrc = '0;
    logic [1:0]  cfg_ssrc = '0;
    logic        cfg_down = 1'b0;
    logic [15:0] cfg_load = '0, cfg_cmp1 = '0, cfg_cmp2 = '0;
    logic [1:0]  cfg_dbg = '0;
    logic        dbg_i = 1'b0, ovf_clr_i = 1'b0;
    logic [15:0] cnt_o;
    logic        cmp1_hit_o, cmp2_hit_o, ovf_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr_chan dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .nbr_i(nbr_i),
        .nbr_dir_i(nbr_dir_i), .cfg_mode(cfg_mode), .cfg_psrc(cfg_psrc),
        .cfg_ssrc(cfg_ssrc), .cfg_down(cfg_down), .cfg_load(cfg_load),
        .cfg_cmp1(cfg_cmp1), .cfg_cmp2(cfg_cmp2), .cfg_dbg(cfg_dbg),
        .dbg_i(dbg_i), .ovf_clr_i(ovf_clr_i), .cnt_o(cnt_o),
        .cmp1_hit_o(cmp1_hit_o), .cmp2_hit_o(cmp2_hit_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pin_i = '0; nbr_i = '0; nbr_dir_i = '0;
        cfg_mode = '0; cfg_psrc = '0; cfg_ssrc = '0; cfg_down = 1'b0;
        cfg_load = '0; cfg_cmp1 = 16'hFFFF; cfg_cmp2 = 16'h8000;
        cfg_dbg = '0; dbg_i = 1'b0; ovf_clr_i = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
    endtask

    task automatic pulse_pin(input int idx, input int n);
        for (int i = 0; i < n; i++) begin
            pin_i[idx] = 1'b1; wait_n(4);
            pin_i[idx] = 1'b0; wait_n(4);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 count", cnt_o, 0);
        chk("R1 hits", {cmp1_hit_o, cmp2_hit_o}, 0);
        chk("R1 ovf", ovf_o, 0);
    endtask

    task automatic t_prescale();
        logic [15:0] a;
        do_reset();
        cfg_psrc = 4'd8; cfg_mode = 3'd1; wait_n(5);
        a = cnt_o; wait_n(10);
        chk("R3 div1", 16'(cnt_o - a), 10);
        cfg_psrc = 4'd11; wait_n(3);
        a = cnt_o; wait_n(64);
        chk("R3 div8", 16'(cnt_o - a), 8);
        cfg_psrc = 4'd15; wait_n(3);
        a = cnt_o; wait_n(256);
        chk("R3 div128", 16'(cnt_o - a), 2);
        cfg_psrc = 4'd8; cfg_mode = 3'd0; wait_n(2);
        a = cnt_o; wait_n(20);
        chk("R2 mode0 hold", 16'(cnt_o - a), 0);
    endtask

    task automatic t_pins();
        logic [15:0] a;
        do_reset();
        cfg_psrc = 4'd0; cfg_ssrc = 2'd1; cfg_mode = 3'd1; wait_n(2);
        a = cnt_o; pulse_pin(0, 3); wait_n(2);
        chk("R4 rising", 16'(cnt_o - a), 3);
        cfg_mode = 3'd2; a = cnt_o; pulse_pin(0, 3); wait_n(2);
        chk("R4 both edges", 16'(cnt_o - a), 6);
        cfg_mode = 3'd1; cfg_down = 1'b1; a = cnt_o; pulse_pin(0, 3); wait_n(2);
        chk("R4 down", 16'(cnt_o - a), 16'hFFFD);
        cfg_down = 1'b0; cfg_mode = 3'd3; a = cnt_o; pulse_pin(0, 2); wait_n(2);
        chk("R5 gate low", 16'(cnt_o - a), 0);
        pin_i[1] = 1'b1; wait_n(4);
        a = cnt_o; pulse_pin(0, 2); wait_n(2);
        chk("R5 gate high", 16'(cnt_o - a), 2);
        cfg_mode = 3'd5; a = cnt_o; pulse_pin(0, 3); wait_n(2);
        chk("R9 sec high down", 16'(cnt_o - a), 16'hFFFD);
        pin_i[1] = 1'b0; wait_n(4);
        a = cnt_o; pulse_pin(0, 2); wait_n(2);
        chk("R9 sec low up", 16'(cnt_o - a), 2);
    endtask

    task automatic t_quad();
        logic [15:0] a;
        do_reset();
        cfg_psrc = 4'd0; cfg_ssrc = 2'd1; cfg_mode = 3'd4; wait_n(4);
        a = cnt_o;
        pin_i[1:0] = 2'b10; wait_n(4);
        pin_i[1:0] = 2'b11; wait_n(4);
        pin_i[1:0] = 2'b01; wait_n(4);
        pin_i[1:0] = 2'b00; wait_n(4);
        chk("R8 forward", 16'(cnt_o - a), 4);
        a = cnt_o;
        pin_i[1:0] = 2'b01; wait_n(4);
        pin_i[1:0] = 2'b11; wait_n(4);
        pin_i[1:0] = 2'b10; wait_n(4);
        chk("R8 reverse", 16'(cnt_o - a), 16'hFFFD);
        a = cnt_o;
        pin_i[1:0] = 2'b01; wait_n(4);
        chk("R8 double change ignored", 16'(cnt_o - a), 0);
    endtask

    task automatic t_reload();
        int h1, h2;
        logic [15:0] at;
        do_reset();
        cfg_load = 16'h0100; cfg_cmp1 = 16'd5; cfg_psrc = 4'd8; cfg_mode = 3'd1;
        h1 = 0; at = '0;
        for (int i = 0; i < 30; i++) begin
            wait_n(1);
            if (cmp1_hit_o) begin h1++; at = cnt_o; end
        end
        chk("R6 up hit count", h1, 1);
        chk("R6 up reload value", at, 16'h0100);
        cfg_load = 16'h01F0; cfg_cmp2 = 16'h00F8; cfg_down = 1'b1;
        h1 = 0; h2 = 0;
        for (int i = 0; i < 60; i++) begin
            wait_n(1);
            if (cmp1_hit_o) h1++;
            if (cmp2_hit_o) begin h2++; at = cnt_o; end
        end
        chk("R6 down hit count", h2, 1);
        chk("R6 down reload value", at, 16'h01F0);
        chk("R6 no up hit while down", h1, 0);
    endtask

    task automatic t_ovf();
        do_reset();
        cfg_load = 16'hFFFC; cfg_cmp1 = 16'd3; cfg_psrc = 4'd8; cfg_mode = 3'd1;
        wait_n(2);
        chk("R7 clear before wrap", ovf_o, 0);
        wait_n(20);
        cfg_mode = 3'd0; wait_n(2);
        chk("R7 set on up wrap", ovf_o, 1);
        wait_n(5);
        chk("R7 sticky", ovf_o, 1);
        ovf_clr_i = 1'b1; wait_n(1); ovf_clr_i = 1'b0; wait_n(1);
        chk("R7 cleared", ovf_o, 0);
        do_reset();
        cfg_down = 1'b1; cfg_psrc = 4'd8; cfg_mode = 3'd1; wait_n(4);
        cfg_mode = 3'd0; wait_n(2);
        chk("R7 set on down wrap", ovf_o, 1);
    endtask

    task automatic t_oneshot();
        int h;
        do_reset();
        cfg_load = 16'h0020; cfg_cmp1 = 16'd4; cfg_psrc = 4'd8; cfg_ssrc = 2'd2;
        cfg_mode = 3'd6; wait_n(10);
        chk("R10 armed holds", cnt_o, 0);
        h = 0;
        pin_i[2] = 1'b1;
        for (int i = 0; i < 24; i++) begin
            wait_n(1);
            if (i == 3) pin_i[2] = 1'b0;
            if (cmp1_hit_o) h++;
        end
        chk("R10 one reload", h, 1);
        chk("R10 done value", cnt_o, 16'h0020);
        pulse_pin(2, 1); wait_n(12);
        chk("R10 done ignores trigger", cnt_o, 16'h0020);
    endtask

    task automatic t_cascade();
        logic [15:0] a;
        do_reset();
        cfg_psrc = 4'd5; cfg_mode = 3'd7; wait_n(2);
        a = cnt_o;
        for (int i = 0; i < 3; i++) begin
            nbr_i[1] = 1'b1; wait_n(1); nbr_i[1] = 1'b0; wait_n(3);
        end
        chk("R11 up", 16'(cnt_o - a), 3);
        nbr_dir_i[1] = 1'b1; a = cnt_o;
        for (int i = 0; i < 2; i++) begin
            nbr_i[1] = 1'b1; wait_n(1); nbr_i[1] = 1'b0; wait_n(3);
        end
        chk("R11 down", 16'(cnt_o - a), 16'hFFFE);
        a = cnt_o;
        nbr_i[2] = 1'b1; wait_n(1); nbr_i[2] = 1'b0; wait_n(3);
        chk("R11 other neighbour ignored", 16'(cnt_o - a), 0);
    endtask

    task automatic t_debug();
        logic [15:0] a;
        int h, moves;
        do_reset();
        cfg_load = 16'd0; cfg_cmp1 = 16'd3; cfg_psrc = 4'd8; cfg_mode = 3'd1;
        dbg_i = 1'b1; cfg_dbg = 2'd1; wait_n(2);
        a = cnt_o; wait_n(10);
        chk("R12 halted", 16'(cnt_o - a), 0);
        cfg_dbg = 2'd2; h = 0; moves = 0; a = cnt_o;
        for (int i = 0; i < 20; i++) begin
            wait_n(1);
            if (cmp1_hit_o || cmp2_hit_o) h++;
            if (cnt_o != a) moves++;
            a = cnt_o;
        end
        chk("R13 hits forced low", h, 0);
        chk("R13 still counting", moves, 20);
        dbg_i = 1'b0; h = 0;
        for (int i = 0; i < 20; i++) begin
            wait_n(1);
            if (cmp1_hit_o) h++;
        end
        chk("R13 no effect outside debug", h, 5);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_prescale();
        t_pins();
        t_quad();
        t_reload();
        t_ovf();
        t_oneshot();
        t_cascade();
        t_debug();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule